// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a synchronous DRAM interface. On every rising clock edge it samples the command strobes, the clock-enable level, the bank select and the address bus. It turns them into one decoded command code, together with its target bank, its address field and its auto-precharge flag. It keeps a small state machine for each of the four banks (idle, active, or active with an auto-precharge pending) and records the row each bank has open. It raises an error flag for any command that the addressed bank cannot take in its present state. A second state machine follows the clock-enable level through the run, suspend, power-down and self-refresh modes.

The clock-enable level from the previous edge is held inside the block. Commands are decoded only when clock enable was high at both the previous and the current edge. A falling clock enable is classified as one of three mode entries, and a rising one as a mode exit. While clock enable stays low the block reports a hold and ignores the command pins. The bank machines have the states IDLE, ACTIVE and AP_PEND. An activate moves IDLE to ACTIVE. A read or write with auto precharge moves ACTIVE to AP_PEND. A single-bank or all-bank precharge moves ACTIVE or AP_PEND to IDLE, and so does an end-of-burst pulse naming the bank while it is in AP_PEND. The power machine has the states RUN, SUSPEND, PDOWN and SREF. RUN moves to one of the other three on the matching entry code, and each of them returns to RUN on the exit code.

All outputs are registered. The decode of the command sampled at one edge, and the bank state that results from it, are visible just after that edge.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: With clock enable high at the previous and current edge and cs_n high, the code is DESEL (1), no error is raised and no bank changes state.
- R2: With cs_n low, the pins {ras_n,cas_n,we_n} decode as follows: 111 is NOP (0), 110 is burst stop BST (8), 001 is auto refresh AREF (9) and 000 is mode register set MRS (7). MRS places the whole address bus on cmd_addr.
- R3: Pins 011 decode as ACT (2). On an idle bank, ACT sets bank_open[ba], stores addr as that bank's row and shows the row on cmd_addr. The bank select value ba (0 to 3) picks the bank and is reported on cmd_bank.
- R4: Pins 010 decode as a precharge. With addr[10] low the code is PRE (3) and only bank ba closes. With addr[10] high the code is PREA (4) and every bank closes.
- R5: Pins 101 decode as READ (5) and 100 as WRITE (6). On an active bank, cmd_addr is addr[8:0] zero-extended, cmd_row is that bank's open row and cmd_ap equals addr[10]. cmd_ap is 0 for every other code.
- R6: An ACT to a bank that is not idle, a READ or WRITE to a bank that is not plainly active, or a BST to an idle bank sets cmd_err and leaves every bank state unchanged.
- R7: MRS or AREF while any bank is open sets cmd_err. Both are accepted without error when all banks are idle.
- R8: A READ or WRITE with addr[10] high keeps the bank open, pending an auto precharge. A burst_done pulse with burst_bank equal to that bank returns it to idle. A burst_done for a bank that is not pending has no effect.
- R9: Clock enable falling (previous high, current low) while any bank is open gives code SUSP_IN (11) and pwr_mode 1.
- R10: Clock enable falling with all banks idle gives SREF_IN (10) and pwr_mode 3 when the pins carry the auto-refresh pattern with cs_n low. Otherwise it gives PDN_IN (12) and pwr_mode 2.
- R11: Clock enable rising gives LP_EXIT (13) and pwr_mode 0. Clock enable low at both edges gives HOLD (14), and the command pins are then ignored.
- R12: After reset all outputs are zero (code NOP, pwr_mode 0, no bank open), and the previous clock-enable level is taken as high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable level at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Address bus; bit 10 is the precharge-all / auto-precharge qualifier |
| burst_done | input | 1 | End-of-burst pulse from the burst generator |
| burst_bank | input | 2 | Bank the end-of-burst pulse refers to |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | 2 | Target bank for bank-specific commands, else 0 |
| cmd_addr | output | 13 | Row for ACT, column for READ/WRITE, op-code for MRS, else 0 |
| cmd_row | output | 13 | Open row of the target bank for READ/WRITE, else 0 |
| cmd_ap | output | 1 | Auto-precharge request of a READ/WRITE |
| cmd_err | output | 1 | Command illegal for the current bank state |
| bank_open | output | 4 | Per-bank not-idle flags |
| pwr_mode | output | 2 | 0 run, 1 suspend, 2 power-down, 3 self-refresh |

## Verification
The assertions on frozen bank state take for granted that no burst_done pulse arrives in the cycle of the command they judge. They also assume that every input is a known level at each sampling edge. The stimulus changes inputs only on falling clock edges and drives every pin to a defined value. It issues end-of-burst pulses only in cycles of their own that carry NOP on the pins, so a command and a bank release never coincide. A behavioural reference model in the bench predicts every output field for each edge, including the cases where the block must ignore a command.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP     = 4'd0,
        CMD_DESEL   = 4'd1,
        CMD_ACT     = 4'd2,
        CMD_PRE     = 4'd3,
        CMD_PREA    = 4'd4,
        CMD_READ    = 4'd5,
        CMD_WRITE   = 4'd6,
        CMD_MRS     = 4'd7,
        CMD_BST     = 4'd8,
        CMD_AREF    = 4'd9,
        CMD_SREF_IN = 4'd10,
        CMD_SUSP_IN = 4'd11,
        CMD_PDN_IN  = 4'd12,
        CMD_LP_EXIT = 4'd13,
        CMD_HOLD    = 4'd14
    } cmd_t;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_ACTIVE  = 2'd1,
        BK_AP_PEND = 2'd2
    } bank_st_t;

    typedef enum logic [1:0] {
        PW_RUN     = 2'd0,
        PW_SUSPEND = 2'd1,
        PW_PDOWN   = 2'd2,
        PW_SREF    = 2'd3
    } pwr_st_t;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_cmd_pkg::*;
#(
    parameter  int BANKS  = 4,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic                   cke_prev,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   a10,
    input  logic [BANK_W-1:0]      ba,
    input  bank_st_t [BANKS-1:0]   bank_st,
    output cmd_t                   code,
    output logic                   err
);

    logic     any_open;
    bank_st_t tgt;

    always_comb begin
        any_open = 1'b0;
        for (int i = 0; i < BANKS; i++) begin
            if (bank_st[i] != BK_IDLE) any_open = 1'b1;
        end
    end

    assign tgt = bank_st[ba];

    // Classify on the clock-enable pair first, then on the strobes
    always_comb begin
        code = CMD_NOP;
        unique case ({cke_prev, cke})
            2'b11: begin
                if (cs_n) begin
                    code = CMD_DESEL;
                end else begin
                    unique case ({ras_n, cas_n, we_n})
                        3'b011:  code = CMD_ACT;
                        3'b010:  code = a10 ? CMD_PREA : CMD_PRE;
                        3'b101:  code = CMD_READ;
                        3'b100:  code = CMD_WRITE;
                        3'b000:  code = CMD_MRS;
                        3'b001:  code = CMD_AREF;
                        3'b110:  code = CMD_BST;
                        default: code = CMD_NOP;
                    endcase
                end
            end
            2'b10: begin
                if (any_open)
                    code = CMD_SUSP_IN;
                else if (!cs_n && !ras_n && !cas_n && we_n)
                    code = CMD_SREF_IN;
                else
                    code = CMD_PDN_IN;
            end
            2'b01:   code = CMD_LP_EXIT;
            default: code = CMD_HOLD;
        endcase
    end

    // Legality against the state of the addressed bank
    always_comb begin
        case (code)
            CMD_ACT:             err = (tgt != BK_IDLE);
            CMD_READ, CMD_WRITE: err = (tgt != BK_ACTIVE);
            CMD_BST:             err = (tgt == BK_IDLE);
            CMD_MRS, CMD_AREF:   err = any_open;
            default:             err = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
    import sdr_cmd_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             ok,
    input  logic             ap,
    input  logic             burst_hit,
    input  cmd_t             code,
    input  logic [ROW_W-1:0] row_in,
    output bank_st_t         state,
    output logic [ROW_W-1:0] row
);

    bank_st_t nxt;
    logic     take;
    logic     closing;

    assign take    = hit && ok;
    assign closing = take && (code == CMD_PRE || code == CMD_PREA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BK_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        row <= '0;
        else if (take && code == CMD_ACT)  row <= row_in;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            BK_IDLE: begin
                if (take && code == CMD_ACT) nxt = BK_ACTIVE;
            end
            BK_ACTIVE: begin
                if (closing)
                    nxt = BK_IDLE;
                else if (take && (code == CMD_READ || code == CMD_WRITE))
                    nxt = ap ? BK_AP_PEND : BK_ACTIVE;
            end
            BK_AP_PEND: begin
                if (burst_hit || closing) nxt = BK_IDLE;
            end
            default: nxt = BK_IDLE;
        endcase
    end

endmodule

// File: rtl/sdr_pwr_fsm.sv
module sdr_pwr_fsm
    import sdr_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cmd_t    code,
    output pwr_st_t mode
);

    pwr_st_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= PW_RUN;
        else        mode <= nxt;
    end

    always_comb begin
        nxt = mode;
        unique case (mode)
            PW_RUN: begin
                if (code == CMD_SUSP_IN)      nxt = PW_SUSPEND;
                else if (code == CMD_PDN_IN)  nxt = PW_PDOWN;
                else if (code == CMD_SREF_IN) nxt = PW_SREF;
            end
            PW_SUSPEND, PW_PDOWN, PW_SREF: begin
                if (code == CMD_LP_EXIT) nxt = PW_RUN;
            end
            default: nxt = PW_RUN;
        endcase
    end

endmodule

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker
    import sdr_cmd_pkg::*;
#(
    parameter  int BANKS  = 4,
    parameter  int ADDR_W = 13,
    parameter  int COL_W  = 9,
    parameter  int AP_BIT = 10,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_done,
    input  logic [BANK_W-1:0] burst_bank,
    output logic [3:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [ADDR_W-1:0] cmd_row,
    output logic              cmd_ap,
    output logic              cmd_err,
    output logic [BANKS-1:0]  bank_open,
    output logic [1:0]        pwr_mode
);

    logic                 cke_q;
    cmd_t                 dec_code;
    logic                 dec_err;
    bank_st_t [BANKS-1:0] bank_st;
    logic [ADDR_W-1:0]    bank_row [BANKS];
    pwr_st_t              mode;
    logic                 is_rw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke;
    end

    sdr_cmd_decode #(.BANKS(BANKS)) u_dec (
        .cke_prev (cke_q),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .a10      (addr[AP_BIT]),
        .ba       (ba),
        .bank_st  (bank_st),
        .code     (dec_code),
        .err      (dec_err)
    );

    for (genvar i = 0; i < BANKS; i++) begin : g_bank
        sdr_bank_fsm #(.ROW_W(ADDR_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       ((ba == BANK_W'(i)) || (dec_code == CMD_PREA)),
            .ok        (!dec_err),
            .ap        (addr[AP_BIT]),
            .burst_hit (burst_done && (burst_bank == BANK_W'(i))),
            .code      (dec_code),
            .row_in    (addr),
            .state     (bank_st[i]),
            .row       (bank_row[i])
        );
        assign bank_open[i] = (bank_st[i] != BK_IDLE);
    end

    sdr_pwr_fsm u_pwr (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (dec_code),
        .mode  (mode)
    );

    assign pwr_mode = mode;
    assign is_rw    = (dec_code == CMD_READ) || (dec_code == CMD_WRITE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_code <= CMD_NOP;
            cmd_bank <= '0;
            cmd_addr <= '0;
            cmd_row  <= '0;
            cmd_ap   <= 1'b0;
            cmd_err  <= 1'b0;
        end else begin
            cmd_code <= dec_code;
            cmd_err  <= dec_err;
            cmd_ap   <= is_rw && addr[AP_BIT];
            cmd_row  <= is_rw ? bank_row[ba] : '0;
            unique case (dec_code)
                CMD_ACT, CMD_PRE, CMD_BST: cmd_bank <= ba;
                CMD_READ, CMD_WRITE:       cmd_bank <= ba;
                default:                   cmd_bank <= '0;
            endcase
            if (dec_code == CMD_ACT || dec_code == CMD_MRS)
                cmd_addr <= addr;
            else if (is_rw)
                cmd_addr <= {{(ADDR_W-COL_W){1'b0}}, addr[COL_W-1:0]};
            else
                cmd_addr <= '0;
        end
    end

endmodule

// File: rtl/sdr_cmd_tracker_chk.sv
module sdr_cmd_tracker_chk
    import sdr_cmd_pkg::*;
#(
    parameter int BANKS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             burst_done,
    input logic [3:0]       cmd_code,
    input logic             cmd_err,
    input logic             cmd_ap,
    input logic [BANKS-1:0] bank_open,
    input logic [1:0]       pwr_mode
);

    AST_DESEL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_DESEL) |-> !cmd_err); // R1

    AST_AP_ONLY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ap |-> (cmd_code == CMD_READ || cmd_code == CMD_WRITE)); // R5

    AST_ERR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err && !$past(burst_done)) |-> $stable(bank_open)); // R6

    AST_SUSP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_SUSP_IN) |-> (pwr_mode == 2'd1 && bank_open != '0)); // R9

    AST_PDN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_PDN_IN) |-> (pwr_mode == 2'd2 && bank_open == '0)); // R10

    AST_EXIT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_LP_EXIT) |-> (pwr_mode == 2'd0)); // R11

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_HOLD && !$past(burst_done)) |-> $stable(bank_open)); // R11

endmodule

bind sdr_cmd_tracker sdr_cmd_tracker_chk #(.BANKS(BANKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_done (burst_done),
    .cmd_code   (cmd_code),
    .cmd_err    (cmd_err),
    .cmd_ap     (cmd_ap),
    .bank_open  (bank_open),
    .pwr_mode   (pwr_mode)
);

// File: tb/sdr_cmd_tracker_bench.sv
module sdr_cmd_tracker_bench;
    import sdr_cmd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic        burst_done = 1'b0;
    logic [1:0]  burst_bank = '0;
    logic [3:0]  cmd_code;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr, cmd_row;
    logic        cmd_ap, cmd_err;
    logic [3:0]  bank_open;
    logic [1:0]  pwr_mode;

    sdr_cmd_tracker u_sdr_cmd_tracker (.*);

    always #10 clk = ~clk;

    int    n_chk = 0, n_fail = 0;
    bit    finished = 0;
    string cur_req = "R12";

    // reference model state
    int          m_st [4];
    logic [12:0] m_row [4];
    bit          m_ckep = 1;
    int          m_pwr = 0;
    int          e_code = 0, e_bank = 0, e_pwr = 0;
    logic [12:0] e_addr = '0, e_row = '0;
    bit          e_ap = 0, e_err = 0;
    logic [3:0]  e_open = '0;
    string       e_req = "R12";

    initial begin
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_row[i] = '0; end
    end

    always @(posedge clk) begin
        int  bk, tgt, code;
        bit  anyo, err, rw;
        e_req = cur_req;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_row[i] = '0; end
            m_ckep = 1; m_pwr = 0;
            e_code = 0; e_bank = 0; e_addr = '0; e_row = '0;
            e_ap = 0; e_err = 0; e_open = '0; e_pwr = 0;
        end else begin
            bk   = int'(ba);
            tgt  = m_st[bk];
            anyo = (m_st[0] != 0) || (m_st[1] != 0) || (m_st[2] != 0) || (m_st[3] != 0);
            if (m_ckep && cke) begin
                if (cs_n) code = 1;
                else case ({ras_n, cas_n, we_n})
                    3'b011: code = 2;
                    3'b010: code = addr[10] ? 4 : 3;
                    3'b101: code = 5;
                    3'b100: code = 6;
                    3'b000: code = 7;
                    3'b001: code = 9;
                    3'b110: code = 8;
                    default: code = 0;
                endcase
            end else if (m_ckep) begin
                if (anyo) code = 11;
                else if (!cs_n && !ras_n && !cas_n && we_n) code = 10;
                else code = 12;
            end else if (cke) code = 13;
            else code = 14;
            rw = (code == 5 || code == 6);
            err = (code == 2 && tgt != 0) || (rw && tgt != 1) ||
                  (code == 8 && tgt == 0) || ((code == 7 || code == 9) && anyo);
            e_code = code; e_err = err;
            e_bank = (code == 2 || code == 3 || code == 8 || rw) ? bk : 0;
            e_addr = (code == 2 || code == 7) ? addr : (rw ? {4'b0, addr[8:0]} : 13'd0);
            e_row  = rw ? m_row[bk] : 13'd0;
            e_ap   = rw && addr[10];
            if (burst_done && m_st[int'(burst_bank)] == 2) m_st[int'(burst_bank)] = 0;
            if (!err) begin
                if (code == 2) begin m_st[bk] = 1; m_row[bk] = addr; end
                else if (code == 3) m_st[bk] = 0;
                else if (code == 4) for (int i = 0; i < 4; i++) m_st[i] = 0;
                else if (rw) m_st[bk] = addr[10] ? 2 : 1;
            end
            if (m_pwr == 0) begin
                if (code == 11) m_pwr = 1;
                else if (code == 12) m_pwr = 2;
                else if (code == 10) m_pwr = 3;
            end else if (code == 13) m_pwr = 0;
            m_ckep = cke;
            e_pwr = m_pwr;
            for (int i = 0; i < 4; i++) e_open[i] = (m_st[i] != 0);
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            n_chk++;
            if (cmd_code !== 4'(e_code) || cmd_bank !== 2'(e_bank) || cmd_addr !== e_addr ||
                cmd_row !== e_row || cmd_ap !== e_ap || cmd_err !== e_err ||
                bank_open !== e_open || pwr_mode !== 2'(e_pwr)) begin
                n_fail++;
                $display("FAIL %s: actual code=%0d bank=%0d addr=%h row=%h ap=%b err=%b open=%b pwr=%0d expected code=%0d bank=%0d addr=%h row=%h ap=%b err=%b open=%b pwr=%0d",
                         e_req, cmd_code, cmd_bank, cmd_addr, cmd_row, cmd_ap, cmd_err, bank_open, pwr_mode,
                         e_code, e_bank, e_addr, e_row, e_ap, e_err, e_open, e_pwr);
            end
        end
    end

    localparam logic [2:0] P_ACT = 3'b011, P_PRE = 3'b010, P_RD = 3'b101, P_WR = 3'b100;
    localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_BST = 3'b110, P_NOP = 3'b111;

    task automatic drive(input string req, input logic c, input logic [2:0] rcw,
                         input logic [1:0] b, input logic [12:0] a, input logic k);
        @(negedge clk);
        cur_req = req; cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a; cke = k;
        burst_done = 1'b0;
    endtask

    task automatic pulse_done(input string req, input logic [1:0] b);
        drive(req, 1'b0, P_NOP, 2'd0, 13'd0, 1'b1);
        burst_done = 1'b1; burst_bank = b;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 4000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R12: watchdog expired, actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive("R12", 1'b0, P_NOP, 2'd0, 13'd0, 1'b1);
        drive("R1",  1'b1, P_ACT, 2'd1, 13'h0AA, 1'b1);   // masked activate
        drive("R3",  1'b0, P_ACT, 2'd0, 13'h1ABC, 1'b1);
        drive("R3",  1'b0, P_ACT, 2'd2, 13'h0123, 1'b1);
        drive("R6",  1'b0, P_ACT, 2'd0, 13'h0555, 1'b1);  // already open
        drive("R5",  1'b0, P_RD,  2'd0, 13'h19F5, 1'b1);
        drive("R5",  1'b0, P_WR,  2'd2, 13'h0A07, 1'b1);
        drive("R6",  1'b0, P_RD,  2'd1, 13'h0010, 1'b1);  // idle bank
        drive("R6",  1'b0, P_BST, 2'd3, 13'h0000, 1'b1);
        drive("R2",  1'b0, P_BST, 2'd0, 13'h0000, 1'b1);
        drive("R7",  1'b0, P_MRS, 2'd0, 13'h0033, 1'b1);
        drive("R7",  1'b0, P_REF, 2'd0, 13'h0000, 1'b1);
        drive("R4",  1'b0, P_PRE, 2'd2, 13'h0000, 1'b1);
        drive("R8",  1'b0, P_RD,  2'd0, 13'h0412, 1'b1);  // auto precharge
        drive("R6",  1'b0, P_WR,  2'd0, 13'h0013, 1'b1);  // pending bank
        pulse_done("R8", 2'd1);                            // ignored
        drive("R6",  1'b0, P_ACT, 2'd0, 13'h0077, 1'b1);
        pulse_done("R8", 2'd0);
        drive("R8",  1'b0, P_NOP, 2'd0, 13'h0000, 1'b1);
        drive("R3",  1'b0, P_ACT, 2'd1, 13'h1111, 1'b1);
        drive("R3",  1'b0, P_ACT, 2'd3, 13'h0FFF, 1'b1);
        drive("R4",  1'b0, P_PRE, 2'd0, 13'h0400, 1'b1);  // all banks
        drive("R2",  1'b0, P_MRS, 2'd1, 13'h1C37, 1'b1);
        drive("R2",  1'b0, P_REF, 2'd0, 13'h0000, 1'b1);
        drive("R1",  1'b1, P_PRE, 2'd0, 13'h0400, 1'b1);
        drive("R3",  1'b0, P_ACT, 2'd1, 13'h0222, 1'b1);
        drive("R9",  1'b0, P_NOP, 2'd0, 13'h0000, 1'b0);
        drive("R11", 1'b0, P_PRE, 2'd1, 13'h0400, 1'b0);  // ignored in hold
        drive("R11", 1'b0, P_NOP, 2'd0, 13'h0000, 1'b1);
        drive("R5",  1'b0, P_WR,  2'd1, 13'h01FF, 1'b1);
        drive("R4",  1'b0, P_PRE, 2'd1, 13'h0000, 1'b1);
        drive("R10", 1'b1, P_NOP, 2'd0, 13'h0000, 1'b0);
        drive("R11", 1'b0, P_ACT, 2'd0, 13'h0000, 1'b0);
        drive("R11", 1'b1, P_NOP, 2'd0, 13'h0000, 1'b1);
        drive("R10", 1'b0, P_REF, 2'd0, 13'h0000, 1'b0);
        drive("R11", 1'b0, P_NOP, 2'd0, 13'h0000, 1'b0);
        drive("R11", 1'b0, P_NOP, 2'd0, 13'h0000, 1'b1);
        drive("R2",  1'b0, P_NOP, 2'd0, 13'h0000, 1'b1);
        drive("R2",  1'b0, P_NOP, 2'd0, 13'h0000, 1'b1);
        @(negedge clk);
        #1;
        finish_run();
    end

endmodule